// File: doc/BRIEF.md
# Operand Stack Cache with Background Spill and Fill

This block keeps the top of an operand stack in a 64-word register file that is used as a ring. The execute side sees a plain stack. It can read the two topmost words at once. In one cycle it can remove up to two words and add one. That covers a binary operation, which consumes two operands and leaves one result, in a single cycle.

A small engine moves words between the ring and data memory without help from software. It has its own read and write path into the ring. When the ring runs high, the engine writes the oldest word out to memory. When the ring runs low and memory still holds words from earlier spills, the engine reads the most recently spilled word back in underneath the oldest word. A memory stack pointer tracks the word address just past the last spilled word. The engine works alongside operand traffic, so the execute side only waits in two cases: when the ring is truly full, or when it asks for more words than the ring holds.

The block stays off after reset. It does nothing until its enable input is raised.

Top module: `opstack_cache`

## Requirements
- R1: After reset `level` is 0, `mem_req` is low and `stall` is high while `enable` is low; the memory stack pointer starts at `MEM_BASE`.
- R2: While `enable` is low, `stall` is high, pushes and pops change neither `level` nor `rd_top`, and no new memory request starts.
- R3: An accepted push places `push_data` on top. `rd_top` shows the newest word and `rd_next` the word below it. `pop_cnt`=1 removes the top word. `level` counts the words held in the ring.
- R4: With `pop_cnt`=2 and `push` set, both operands are readable on `rd_top` and `rd_next` in the accepting cycle, the pushed word becomes the new top, and `level` falls by one.
- R5: A push with `pop_cnt`=0 stalls when the ring holds 64 words, counting a slot reserved for a pending fill. A push combined with a pop at 64 words proceeds. `level` never exceeds 64.
- R6: A pop stalls when `pop_cnt` exceeds the words available, which is `level` minus one while a spill is pending. It proceeds once a fill supplies the words.
- R7: When the engine is idle, enabled and `level` is at least 56, it issues a write (`mem_we`=1) of the oldest word to `mem_addr` equal to the memory stack pointer. On acknowledge the pointer rises by 4 and `level` falls by 1, so spilling stops at 55.
- R8: When the engine is idle, enabled, `level` is below 8 and the pointer is above `MEM_BASE`, it issues a read (`mem_we`=0) at pointer minus 4. On acknowledge `mem_rdata` becomes the new oldest word, the pointer falls by 4 and `level` rises by 1, so pop order stays last-in-first-out across memory.
- R9: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold steady until `mem_ack`. Each request moves one word. `mem_req` is low in the cycle after an acknowledge.
- R10: Pushes and pops keep being accepted with no stall while a memory request is outstanding, subject only to the limits in R5 and R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Turns the cache on |
| push | input | 1 | Add `push_data` on top |
| pop_cnt | input | 2 | Words removed this cycle (0 to 2; 3 acts as 2) |
| push_data | input | WIDTH | Word to add |
| rd_top | output | WIDTH | Topmost word |
| rd_next | output | WIDTH | Word below the top |
| stall | output | 1 | Request not taken this cycle |
| level | output | clog2(DEPTH+1) | Words held in the ring |
| mem_req | output | 1 | Memory request pending |
| mem_we | output | 1 | 1 = spill write, 0 = fill read |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | WIDTH | Word being spilled |
| mem_ack | input | 1 | Request completes this cycle |
| mem_rdata | input | WIDTH | Word returned by a fill |

## Verification
`stall` is combinational on the current inputs and registered state. It is therefore valid within the same cycle, and the bench samples it 1 ns after the falling edge at which it drives. `rd_top`, `rd_next` and `level` reflect an accepted operation one rising edge later, so each operand check is made while the pop is being accepted and each level check at the next falling edge. A memory request appears one edge after `level` crosses a watermark. Its effect on `level` and the pointer lands on the acknowledge edge, and `mem_req` is low in the following cycle, so the memory model acknowledges at a falling edge and records the address it expects before the next rising edge.

// File: rtl/opstack_cache.sv
`timescale 1ns/1ps
module opstack_cache #(
  parameter int DEPTH   = 64,
  parameter int WIDTH   = 32,
  parameter int AW      = 32,
  parameter int HI_MARK = 56,
  parameter int LO_MARK = 8,
  parameter logic [AW-1:0] MEM_BASE = 'h1000
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         enable,
  input  logic                         push,
  input  logic [1:0]                   pop_cnt,
  input  logic [WIDTH-1:0]             push_data,
  output logic [WIDTH-1:0]             rd_top,
  output logic [WIDTH-1:0]             rd_next,
  output logic                         stall,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic                         mem_req,
  output logic                         mem_we,
  output logic [AW-1:0]                mem_addr,
  output logic [WIDTH-1:0]             mem_wdata,
  input  logic                         mem_ack,
  input  logic [WIDTH-1:0]             mem_rdata
);
  // DEPTH must be a power of two so ring indices wrap naturally.
  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
  localparam logic [CW-1:0] HI_C   = CW'(HI_MARK);
  localparam logic [CW-1:0] LO_C   = CW'(LO_MARK);
  localparam logic [AW-1:0] STEP   = AW'(WIDTH / 8);

  logic [WIDTH-1:0] ram [DEPTH];
  logic [IW-1:0]    bot;
  logic [CW-1:0]    cnt;
  logic [AW-1:0]    msp;
  logic             busy, fill_op;
  logic [AW-1:0]    addr_q;
  logic [WIDTH-1:0] wdata_q;

  logic [CW-1:0] pops, avail, occ, taken;
  logic          spill_res, fill_res, spill_done, fill_done;
  logic          go, do_push, start_spill, start_fill;
  logic [IW-1:0] top_idx, wr_idx, fill_idx;

  assign pops       = (pop_cnt == 2'd3) ? CW'(2) : CW'(pop_cnt);
  assign spill_res  = busy & ~fill_op;
  assign fill_res   = busy & fill_op;
  assign avail      = cnt - CW'(spill_res);
  assign occ        = cnt + CW'(fill_res);
  assign stall      = ~enable | (pops > avail) | (push & (pops == '0) & (occ == FULL_C));
  assign go         = ~stall;
  assign do_push    = go & push;
  assign taken      = go ? pops : '0;
  assign spill_done = spill_res & mem_ack;
  assign fill_done  = fill_res & mem_ack;

  assign start_spill = enable & ~busy & (cnt >= HI_C);
  assign start_fill  = enable & ~busy & ~start_spill & (cnt < LO_C) & (msp != MEM_BASE);

  assign top_idx  = bot + IW'(cnt) - IW'(1);
  assign wr_idx   = bot + IW'(cnt) - IW'(pops);
  assign fill_idx = bot - IW'(1);

  assign rd_top    = ram[top_idx];
  assign rd_next   = ram[top_idx - IW'(1)];
  assign level     = cnt;
  assign mem_req   = busy;
  assign mem_we    = ~fill_op;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;

  // Two synchronous write ports: operand result and fill return.
  always_ff @(posedge clk) begin
    if (do_push)   ram[wr_idx]   <= push_data;
    if (fill_done) ram[fill_idx] <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      bot     <= '0;
      msp     <= MEM_BASE;
      busy    <= 1'b0;
      fill_op <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      cnt <= cnt - taken + CW'(do_push) + CW'(fill_done) - CW'(spill_done);
      bot <= bot + IW'(spill_done) - IW'(fill_done);
      if (spill_done)     msp <= msp + STEP;
      else if (fill_done) msp <= msp - STEP;
      if (busy) begin
        if (mem_ack) busy <= 1'b0;
      end else if (start_spill | start_fill) begin
        busy    <= 1'b1;
        fill_op <= start_fill;
        addr_q  <= start_fill ? msp - STEP : msp;
        wdata_q <= ram[bot];
      end
    end
  end

  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  a_r9_gap_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack |=> !mem_req);
  a_r2_off_stall: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> stall);
  a_r2_no_new_req: assert property (@(posedge clk) disable iff (!rst_n)
    !enable && !mem_req |=> !mem_req);
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    level <= FULL_C);
  a_r7_spill_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) && mem_we |-> $past(level) >= HI_C);
  a_r8_fill_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) && !mem_we |-> $past(level) < LO_C);
  a_r3_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    !stall && push && pop_cnt == 2'd0 && !(mem_req && mem_ack) |=> level == $past(level) + CW'(1));
endmodule

// File: tb/opstack_cache_bench.sv
`timescale 1ns/1ps
module opstack_cache_bench;
  localparam logic [31:0] BASE = 32'h1000;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, push = 1'b0;
  logic [1:0] pop_cnt = 2'd0;
  logic [31:0] push_data = '0;
  logic [31:0] rd_top, rd_next, mem_addr, mem_wdata;
  logic stall, mem_req, mem_we;
  logic [6:0] level;
  logic mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  int errors = 0, checks = 0, waits = 0, lat = 0;
  bit done = 0, hold = 0;
  logic [31:0] model[$];
  logic [31:0] exp_q[$];
  logic [31:0] dmem [logic [31:0]];
  logic [31:0] bmsp = BASE;

  opstack_cache u_opstack_cache (
    .clk(clk), .rst_n(rst_n), .enable(enable), .push(push), .pop_cnt(pop_cnt),
    .push_data(push_data), .rd_top(rd_top), .rd_next(rd_next), .stall(stall),
    .level(level), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata));

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Memory model: acknowledges after a short wait, tracks the expected pointer.
  always @(negedge clk) begin
    mem_ack = 1'b0;
    if (mem_req && !hold) begin
      if (lat >= 2) begin
        lat = 0;
        mem_ack = 1'b1;
        if (mem_we) begin
          check(mem_addr == bmsp, "R7 spill address", mem_addr, bmsp);
          dmem[mem_addr] = mem_wdata;
          bmsp += 4;
        end else begin
          check(mem_addr == bmsp - 4, "R8 fill address", mem_addr, bmsp - 4);
          mem_rdata = dmem.exists(mem_addr) ? dmem[mem_addr] : 32'hDEAD_BEEF;
          bmsp -= 4;
        end
      end else lat++;
    end
  end

  // Scoreboard monitor: compares operands of each accepted pop.
  always @(negedge clk) begin
    #1;
    if (rst_n && enable && !stall && pop_cnt != 2'd0 && exp_q.size() > 0) begin
      logic [31:0] e;
      e = exp_q.pop_front();
      check(rd_top == e, "R3 popped top", rd_top, e);
      if (pop_cnt == 2'd2 && exp_q.size() > 0) begin
        e = exp_q.pop_front();
        check(rd_next == e, "R4 second operand", rd_next, e);
      end
    end
  end

  task automatic op(input int npop, input bit dpush, input logic [31:0] d);
    @(negedge clk);
    if (npop >= 1) exp_q.push_back(model[$]);
    if (npop == 2) exp_q.push_back(model[$-1]);
    pop_cnt = 2'(npop);
    push = dpush;
    push_data = d;
    waits = 0;
    #1;
    while (stall) begin
      @(negedge clk);
      #1;
      waits++;
    end
    @(posedge clk);
    for (int k = 0; k < npop; k++) void'(model.pop_back());
    if (dpush) model.push_back(d);
    #1;
    pop_cnt = 2'd0;
    push = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog R1..: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] s;
    int n;
    bit pend_ok;
    repeat (3) @(negedge clk);
    #1;
    check(level == 0, "R1 level after reset", 32'(level), 0);
    check(stall == 1'b1, "R1 stall while off", 32'(stall), 1);
    check(mem_req == 1'b0, "R1 no request", 32'(mem_req), 0);
    @(negedge clk);
    rst_n = 1'b1;
    push = 1'b1; push_data = 32'h5555_0000;
    repeat (3) @(negedge clk);
    #1;
    check(level == 0, "R2 push ignored while off", 32'(level), 0);
    check(stall == 1'b1, "R2 stall while off", 32'(stall), 1);
    @(negedge clk);
    push = 1'b0; enable = 1'b1; pop_cnt = 2'd1;
    #1;
    check(stall == 1'b1, "R6 pop on empty stalls", 32'(stall), 1);
    @(negedge clk);
    pop_cnt = 2'd0;

    op(0, 1, 32'hA);
    op(0, 1, 32'hB);
    op(0, 1, 32'hC);
    @(negedge clk); #1;
    check(level == 3, "R3 level after pushes", 32'(level), 3);
    check(rd_top == 32'hC, "R3 top", rd_top, 32'hC);
    check(rd_next == 32'hB, "R3 next", rd_next, 32'hB);

    @(negedge clk);
    enable = 1'b0; push = 1'b1; push_data = 32'h77; pop_cnt = 2'd2;
    repeat (2) @(negedge clk);
    push = 1'b0; pop_cnt = 2'd0; enable = 1'b1;
    #1;
    check(level == 3, "R2 ops ignored while off", 32'(level), 3);
    check(rd_top == 32'hC, "R2 top unchanged", rd_top, 32'hC);

    s = model[$] + model[$-1];
    op(2, 1, s);
    @(negedge clk); #1;
    check(level == 2, "R4 level after pop2 push1", 32'(level), 2);
    check(rd_top == s, "R4 result on top", rd_top, s);
    check(rd_next == 32'hA, "R4 below result", rd_next, 32'hA);

    hold = 1;
    pend_ok = 1;
    for (int i = 0; i < 62; i++) begin
      op(0, 1, 32'h1000_0000 + 32'(i));
      if (waits != 0) pend_ok = 0;
    end
    @(negedge clk); #1;
    check(pend_ok, "R10 pushes accepted during pending spill", 32'(pend_ok), 1);
    check(level == 64, "R10 level reached full", 32'(level), 64);
    check(mem_req && mem_we, "R7 spill requested", {30'd0, mem_req, mem_we}, 32'd3);
    check(mem_addr == BASE, "R9 address held", mem_addr, BASE);
    check(mem_wdata == 32'hA, "R7 oldest word spilled", mem_wdata, 32'hA);
    @(negedge clk);
    push = 1'b1; push_data = 32'hEE;
    #1;
    check(stall == 1'b1, "R5 push at full stalls", 32'(stall), 1);
    @(negedge clk);
    push = 1'b0;
    #1;
    check(level == 64, "R5 level unchanged", 32'(level), 64);
    op(1, 1, 32'hF00D);
    @(negedge clk); #1;
    check(level == 64, "R5 pop+push at full", 32'(level), 64);
    check(rd_top == 32'hF00D, "R5 top replaced", rd_top, 32'hF00D);

    hold = 0;
    for (int i = 0; i < 20; i++) op(0, 1, 32'h2000_0000 + 32'(i));
    repeat (200) @(negedge clk);
    #1;
    check(level == 55, "R7 spilling stops below mark", 32'(level), 55);
    check(mem_req == 1'b0, "R9 engine idle", 32'(mem_req), 0);
    n = model.size() - 55;
    check(bmsp == BASE + 32'(4 * n), "R7 pointer advance", bmsp, BASE + 32'(4 * n));
    for (int i = 0; i < n; i++) begin
      logic [31:0] a;
      a = BASE + 32'(4 * i);
      check(dmem.exists(a) && dmem[a] == model[i], "R7 spilled contents", dmem.exists(a) ? dmem[a] : 32'hX, model[i]);
    end

    while (model.size() > 0) begin
      if (model.size() >= 2 && model.size() % 3 == 0) op(2, 0, 32'h0);
      else op(1, 0, 32'h0);
    end
    repeat (20) @(negedge clk);
    #1;
    check(level == 0, "R8 drained", 32'(level), 0);
    check(mem_req == 1'b0, "R8 no request when empty", 32'(mem_req), 0);
    check(bmsp == BASE, "R8 pointer back at base", bmsp, BASE);
    check(exp_q.size() == 0, "R3 all pops compared", 32'(exp_q.size()), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule